// File: doc/BRIEF.md
# Bit-Serial Four-Times Interpolation Filter

This block raises the rate of an 18-bit signed audio stream by four. Two recursive two-times stages are chained. Each stage stuffs a zero sample between its inputs and then smooths the result with a first-order low-pass recursion. The recursion uses only power-of-two coefficients, so every multiply is a shift, and each update is computed one bit per clock, least significant bit first, over a 22-bit sign-extended word.

One fast clock runs the whole block. A one-cycle `word_tick` strobe marks each output slot at four times the input rate. A sample is offered by raising `in_valid` together with a tick. That tick and the next three accepted ticks each start one serial pass of `WORD_W` clock cycles. Every pass ends in a single `out_valid` pulse carrying a saturated 22-bit result, which is the final filter state scaled up by `OUT_SHIFT` bits.

Top module: `quad_interp_filter`

## Requirements
- R1: After reset, `out_valid` is low, `out_sample` is zero and both filter states are zero.
- R2: A sample is taken only on a clock where `word_tick` and `in_valid` are both high, no pass is running and no slot of the previous sample is still outstanding. On a tick with a slot outstanding, `in_valid` and `in_sample` have no effect and that tick serves the next slot.
- R3: Each taken sample produces exactly four `out_valid` pulses. Slot 0 belongs to the tick that takes the sample and slots 1, 2 and 3 belong to the next three ticks that find the block idle. Each pulse lasts one cycle.
- R4: The first stage updates only in slots 0 and 2, as s1 = s1 - floor(s1/2) + x in slot 0 (x is the sample sign-extended) and s1 = s1 - floor(s1/2) in slot 2. In slots 1 and 3 it holds its value.
- R5: The second stage updates in every slot, as s2 = s2 - floor(s2/2) + u. Here u is the first-stage value from before this slot's update in slots 0 and 2, and zero in slots 1 and 3.
- R6: `out_sample` equals s2 multiplied by 2^OUT_SHIFT (16 by default), clamped to the signed 22-bit range [-2097152, 2097151].
- R7: `out_valid` rises `WORD_W` rising edges after the edge that samples the tick starting the pass, which is 22 edges at the defaults.
- R8: A `word_tick` that arrives while a pass is running is ignored. It adds no pulse and does not advance the slot.
- R9: A `word_tick` with `in_valid` low and no slot outstanding produces no pulse and leaves the filter state unchanged.
- R10: Neither serial recursion overflows the 22-bit word for any 18-bit input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial processing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_tick | input | 1 | One-cycle strobe at four times the input rate |
| in_valid | input | 1 | Offers `in_sample` on a tick |
| in_sample | input | 18 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse per output slot |
| out_sample | output | 22 | Signed saturated output sample |

## Verification
The bench builds the block with its default parameters: an 18-bit input, a 22-bit serial word, a feedback shift of one and an output shift of four. At full-scale input, the shift of four carries the peaks of the second stage past the 22-bit range. Constant full-scale samples of either sign and alternating large samples therefore reach both saturation limits. An impulse and a run of pseudo-random samples reach the unsaturated recursion. Ticks placed in the middle of a pass, samples offered while slots are outstanding, and a bare idle tick reach the cases in which the block must ignore its inputs.

// File: rtl/qi_pkg.sv
package qi_pkg;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_SHIFT = 1'b1
  } seq_state_e;

  // One-bit full adder: returns {carry, sum}.
  function automatic logic [1:0] full_add(input logic a, input logic b, input logic c);
    return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

  // True when the lowest n bits of v are all zero.
  function automatic logic low_zero2(input logic [1:0] v, input int unsigned n);
    logic z;
    z = 1'b1;
    for (int i = 0; i < 2; i++) begin
      if (i < int'(n) && v[i]) z = 1'b0;
    end
    return z;
  endfunction

endpackage

// File: rtl/qi_sequencer.sv
module qi_sequencer
  import qi_pkg::*;
#(
  parameter int unsigned WORD_W = 22,
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_tick,
  input  logic              in_valid,
  output logic              accept,
  output logic              start,
  output logic              step,
  output logic              last,
  output logic [SLOT_W-1:0] slot_nx
);

  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [SLOT_W-1:0] rem_q;
  logic [SLOT_W-1:0] slot_q;
  logic              idle;
  logic              cont;

  assign idle   = (state_q == PH_IDLE);
  assign accept = idle && word_tick && in_valid && (rem_q == '0);
  assign cont   = idle && word_tick && (rem_q != '0);
  assign start  = accept || cont;
  assign step   = (state_q == PH_SHIFT);
  assign last   = step && (bcnt_q == LAST_BIT);

  always_comb begin
    if (accept)    slot_nx = '0;
    else if (cont) slot_nx = slot_q + SLOT_W'(1);
    else           slot_nx = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      bcnt_q  <= '0;
      rem_q   <= '0;
      slot_q  <= '0;
    end else if (start) begin
      state_q <= PH_SHIFT;
      bcnt_q  <= '0;
      slot_q  <= slot_nx;
      rem_q   <= accept ? '1 : rem_q - SLOT_W'(1);
    end else if (last) begin
      state_q <= PH_IDLE;
    end else if (step) begin
      bcnt_q <= bcnt_q + CNT_W'(1);
    end
  end

  AST_PASS_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> step) else $error("pass did not start");                    // R7
  AST_PASS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !step) else $error("pass did not end");                      // R7
  AST_BUSY_TICK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && word_tick) |=> ($stable(rem_q) && $stable(slot_q)))
    else $error("tick during pass changed slot state");                   // R8
  AST_VALID_IGNORED_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && word_tick && in_valid && rem_q != '0) |=> (slot_q != '0))
    else $error("sample taken while slots outstanding");                  // R2

endmodule

// File: rtl/qi_serial_stage.sv
module qi_serial_stage
  import qi_pkg::*;
#(
  parameter int unsigned WORD_W   = 22,
  parameter int unsigned FB_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              last,
  input  logic              en_in,
  input  logic [WORD_W-1:0] x_in,
  output logic [WORD_W-1:0] y_q,
  output logic [WORD_W-1:0] y_next
);

  logic [WORD_W-1:0] y_sr;
  logic [WORD_W-1:0] x_sr;
  logic [WORD_W-1:0] res_sr;
  logic              c_sub_q, c_add_q;
  logic              en_q;
  logic              d_bit, s_bit, c_sub_n, c_add_n;

  // y - (y >>> FB_SHIFT) + x, one bit per clock. The shift registers
  // replicate the sign, so the upper taps read sign-extended bits.
  always_comb begin
    {c_sub_n, d_bit} = full_add(y_sr[0], ~y_sr[FB_SHIFT], c_sub_q);
    {c_add_n, s_bit} = full_add(d_bit, x_sr[0], c_add_q);
  end

  assign y_next = {s_bit, res_sr[WORD_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q     <= '0;
      y_sr    <= '0;
      x_sr    <= '0;
      res_sr  <= '0;
      c_sub_q <= 1'b0;
      c_add_q <= 1'b0;
      en_q    <= 1'b0;
    end else if (load) begin
      y_sr    <= y_q;
      x_sr    <= x_in;
      c_sub_q <= 1'b1;
      c_add_q <= 1'b0;
      en_q    <= en_in;
    end else if (step) begin
      y_sr    <= {y_sr[WORD_W-1], y_sr[WORD_W-1:1]};
      x_sr    <= {x_sr[WORD_W-1], x_sr[WORD_W-1:1]};
      res_sr  <= y_next;
      c_sub_q <= c_sub_n;
      c_add_q <= c_add_n;
      if (last && en_q) y_q <= y_next;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> ((c_sub_q == c_sub_n) && (c_add_q == c_add_n)))
    else $error("serial recursion overflowed");                           // R10
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !en_q) |=> $stable(y_q)) else $error("disabled stage moved"); // R4

endmodule

// File: rtl/qi_saturate.sv
module qi_saturate #(
  parameter int unsigned WORD_W    = 22,
  parameter int unsigned OUT_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [WORD_W-1:0] y_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_sample
);

  localparam int unsigned EXT_W = WORD_W + OUT_SHIFT;
  localparam logic signed [EXT_W-1:0] MAX_V = {{(OUT_SHIFT+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MIN_V = {{(OUT_SHIFT+1){1'b1}}, {(WORD_W-1){1'b0}}};

  function automatic logic [WORD_W-1:0] sat_shift(input logic [WORD_W-1:0] y);
    logic signed [EXT_W-1:0] wide;
    wide = $signed({{OUT_SHIFT{y[WORD_W-1]}}, y}) <<< OUT_SHIFT;
    if (wide > MAX_V)      return MAX_V[WORD_W-1:0];
    else if (wide < MIN_V) return MIN_V[WORD_W-1:0];
    else                   return wide[WORD_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= valid_in;
      if (valid_in) out_sample <= sat_shift(y_in);
    end
  end

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample)) else $error("output moved without pulse"); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid) else $error("pulse longer than one cycle");         // R3

endmodule

// File: rtl/quad_interp_filter.sv
module quad_interp_filter
  import qi_pkg::*;
#(
  parameter int unsigned IN_W      = 18,
  parameter int unsigned WORD_W    = 22,
  parameter int unsigned FB_SHIFT  = 1,
  parameter int unsigned OUT_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_tick,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_sample,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_sample
);

  localparam int unsigned STAGES = 2;
  localparam int unsigned SLOT_W = STAGES;
  localparam int unsigned PULSES = 1 << STAGES;

  logic              accept, start, step, last;
  logic [SLOT_W-1:0] slot_nx;
  logic [WORD_W-1:0] y_q_arr    [STAGES];
  logic [WORD_W-1:0] y_next_arr [STAGES];

  qi_sequencer #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .word_tick(word_tick), .in_valid(in_valid),
    .accept(accept), .start(start), .step(step), .last(last), .slot_nx(slot_nx)
  );

  // Stage s runs in slots whose low (STAGES-1-s) bits are zero and takes a
  // non-zero input only where its low (STAGES-s) bits are zero.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] x_sel;
    logic              en_sel;
    if (s == 0) begin : g_first
      assign src = {{(WORD_W-IN_W){in_sample[IN_W-1]}}, in_sample};
    end else begin : g_next
      assign src = y_q_arr[s-1];
    end
    assign x_sel  = low_zero2(slot_nx, STAGES - s) ? src : '0;
    assign en_sel = low_zero2(slot_nx, STAGES - 1 - s);

    qi_serial_stage #(.WORD_W(WORD_W), .FB_SHIFT(FB_SHIFT)) u_stage (
      .clk(clk), .rst_n(rst_n), .load(start), .step(step), .last(last),
      .en_in(en_sel), .x_in(x_sel), .y_q(y_q_arr[s]), .y_next(y_next_arr[s])
    );
  end

  qi_saturate #(.WORD_W(WORD_W), .OUT_SHIFT(OUT_SHIFT)) u_sat (
    .clk(clk), .rst_n(rst_n), .valid_in(last), .y_in(y_next_arr[STAGES-1]),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  // Pulse tally per taken sample, kept only for the check below.
  logic [3:0] pulse_cnt_q;
  logic       seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt_q <= '0;
      seen_q      <= 1'b0;
    end else if (accept) begin
      pulse_cnt_q <= '0;
      seen_q      <= 1'b1;
    end else if (out_valid) begin
      pulse_cnt_q <= pulse_cnt_q + 4'd1;
    end
  end

  AST_FOUR_PER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && seen_q) |-> ((pulse_cnt_q + {3'd0, out_valid}) == 4'(PULSES)))
    else $error("wrong pulse count for previous sample");                // R3

endmodule

// File: tb/quad_interp_filter_tb.sv
module quad_interp_filter_tb_top;

  localparam int W = 22;
  localparam longint SAT_HI = 2097151;
  localparam longint SAT_LO = -2097152;

  typedef struct {
    longint data;
    longint cyc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_tick = 1'b0;
  logic        in_valid = 1'b0;
  logic [17:0] in_sample = '0;
  logic        out_valid;
  logic [21:0] out_sample;

  int     vectors = 0;
  int     miscompares = 0;
  longint cyc = 0;
  int     pulses = 0;
  int     taken = 0;

  exp_t   q[$];
  longint m_s1 = 0, m_s2 = 0, m_x = 0;
  int     m_rem = 0;

  quad_interp_filter dut_i (
    .clk(clk), .rst_n(rst_n), .word_tick(word_tick), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(out_valid), .out_sample(out_sample)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of one slot, restated from the requirements.
  task automatic model_slot(input int k, input longint edge_cyc);
    longint u;
    longint v;
    exp_t   e;
    u = (k % 2 == 0) ? m_s1 : 0;
    if (k == 0) m_s1 = m_s1 - (m_s1 >>> 1) + m_x;
    if (k == 2) m_s1 = m_s1 - (m_s1 >>> 1);
    m_s2 = m_s2 - (m_s2 >>> 1) + u;
    v = m_s2 * 16;
    if (v > SAT_HI) v = SAT_HI;
    if (v < SAT_LO) v = SAT_LO;
    e.data = v;
    e.cyc  = edge_cyc + W;
    q.push_back(e);
  endtask

  // Driver: one tick; busy=1 marks a tick sent during a pass (R8).
  task automatic tick(input bit v, input int s, input bit busy);
    @(negedge clk);
    word_tick = 1'b1;
    in_valid  = v;
    in_sample = 18'(s);
    if (!busy) begin
      if (m_rem == 0 && v) begin
        m_x = longint'(s);
        m_rem = 3;
        taken++;
        model_slot(0, cyc + 1);
      end else if (m_rem > 0) begin
        model_slot(4 - m_rem, cyc + 1);
        m_rem--;
      end
    end
    @(negedge clk);
    word_tick = 1'b0;
    in_valid  = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic feed(input int s);
    tick(1'b1, s, 1'b0);
    gap(W + 2);
    for (int k = 1; k < 4; k++) begin
      tick(1'b0, 0, 1'b0);
      gap(W + 2);
    end
  endtask

  // Monitor: pops the scoreboard on every pulse.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      pulses++;
      if (q.size() == 0) begin
        check(1'b0, "R3 unexpected pulse", longint'($signed(out_sample)), 0);
      end else begin
        e = q.pop_front();
        check(longint'($signed(out_sample)) == e.data, "R5/R6 sample",
              longint'($signed(out_sample)), e.data);
        check(cyc == e.cyc, "R7 latency", cyc, e.cyc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=0", q.size());
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int p0;
    int lcg;
    gap(3);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(out_sample == '0, "R1 out_sample", longint'($signed(out_sample)), 0);
    rst_n = 1'b1;
    gap(3);
    check(out_valid == 1'b0, "R1 out_valid after release", longint'(out_valid), 0);

    // R9: bare tick while idle
    p0 = pulses;
    tick(1'b0, 0, 1'b0);
    gap(W + 4);
    check(pulses == p0, "R9 idle tick", longint'(pulses), longint'(p0));

    // R4/R5: impulse then zeros
    feed(131071);
    for (int i = 0; i < 5; i++) feed(0);

    // R6: full-scale runs of both signs reach both limits
    for (int i = 0; i < 6; i++) feed(-131072);
    for (int i = 0; i < 6; i++) feed(131071);
    for (int i = 0; i < 4; i++) feed((i % 2 == 0) ? 65536 : -65536);

    // R8: extra tick in the middle of a pass
    tick(1'b1, 4000, 1'b0);
    gap(4);
    tick(1'b0, 0, 1'b1);
    gap(W);
    for (int k = 1; k < 4; k++) begin
      tick(1'b0, 0, 1'b0);
      gap(4);
      tick(1'b1, 777, 1'b1);
      gap(W);
    end

    // R2: in_valid with outstanding slots must not take the new sample
    tick(1'b1, -5000, 1'b0);
    gap(W + 2);
    for (int k = 1; k < 4; k++) begin
      tick(1'b1, 99999 - k, 1'b0);
      gap(W + 2);
    end

    // pseudo-random samples
    lcg = 12345;
    for (int i = 0; i < 12; i++) begin
      lcg = lcg * 1103515245 + 12345;
      feed(((lcg >>> 8) % 131072));
    end

    gap(W + 6);
    // R3: every expected pulse seen, four per taken sample
    check(q.size() == 0, "R3 pending pulses", longint'(q.size()), 0);
    check(pulses == 4 * taken, "R3 pulse total", longint'(pulses), longint'(4 * taken));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule